// File: doc/BRIEF.md
# VGA Offset-Window Timing Generator

This block produces the raster timing for a display that shows a 512 by 384 picture inside a standard 800 by 525 clock frame of the 640x480 class. A fast system clock drives it. An internal prescaler divides that clock by four to make a pixel-rate tick. For example, a 100.5 MHz clock gives a 25.125 MHz pixel rate. On every tick a horizontal counter advances. At the end of each line a vertical counter advances. Downstream logic, such as a character generator or a colour stage, uses the counts, the active-area flags and the two sync pulses to build the picture.

Both sync pulses are active-high. Their start positions are parameters, so the picture can be moved on a monitor while the pulse widths stay the same. Each axis is a small state machine with four named states: `SEG_ACTIVE` (visible), `SEG_FRONT` (blank before sync), `SEG_SYNC` (sync asserted) and `SEG_BACK` (blank after sync). A state changes only on an advance of that axis. The transitions are:
- *ACTIVE to FRONT* from the last visible count.
- *FRONT to SYNC* from the count just before the sync start.
- *SYNC to BACK* from the last sync count.
- *BACK to ACTIVE* from the last count of the axis, when the counter wraps to zero.

Every output is decoded from registers. No output has a combinational path from an input. A synchronous reset puts both axes at count zero in `SEG_ACTIVE`.

Top module: `vga_offset_timing`

## Requirements
- R1: `pix_tick` is high for one clock in every `CLK_DIV` (default 4). The first high clock is the third clock after reset is released. The counters advance on the clock edges where `pix_tick` is high.
- R2: `pix_x` counts 0 to `H_TOTAL-1` (default 799), one step per tick, then wraps to 0.
- R3: `line_y` counts 0 to `V_TOTAL-1` (default 524). It advances only on a tick while `pix_x` is `H_TOTAL-1`, and wraps to 0 after its last value.
- R4: `h_active` is high exactly when `pix_x` < `H_ACTIVE` (default 512). `v_active` is high exactly when `line_y` < `V_ACTIVE` (default 384).
- R5: `hsync` is high exactly when `H_SYNC_START` <= `pix_x` < `H_SYNC_START+H_SYNC_WIDTH` (defaults 592 and 96, so pixels 592 to 687).
- R6: `vsync` is high exactly when `V_SYNC_START` <= `line_y` < `V_SYNC_START+V_SYNC_WIDTH` (defaults 443 and 3, so lines 443 to 445).
- R7: `line_end` is high exactly while `pix_x` is `H_TOTAL-1`. `frame_start` is high exactly while `pix_x` and `line_y` are both 0, which is one pixel period.
- R8: While reset is held at a clock edge, the edge sets these values: `pix_x`=0, `line_y`=0, `h_active`=1, `v_active`=1, `hsync`=0, `vsync`=0, `line_end`=0, `frame_start`=1 and `pix_tick`=0.
- R9: On a clock edge where `pix_tick` is low, `pix_x`, `line_y`, `hsync` and `vsync` do not change.
- R10: Changing `H_SYNC_START` or `V_SYNC_START` moves its pulse to the new start position. The pulse width stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, a multiple `CLK_DIV` of the pixel rate |
| rst | input | 1 | Synchronous reset, active high |
| pix_tick | output | 1 | Pixel-rate enable, high one clock in `CLK_DIV` |
| pix_x | output | $clog2(H_TOTAL) | Horizontal pixel count |
| line_y | output | $clog2(V_TOTAL) | Vertical line count |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| h_active | output | 1 | Pixel is inside the visible columns |
| v_active | output | 1 | Line is inside the visible rows |
| line_end | output | 1 | Last pixel of the line |
| frame_start | output | 1 | First pixel of the frame |

## Verification
The region flags come from state machines rather than from comparators, so a state that falls out of step with its counter shows at once. The flags and syncs then disagree with the counts in the same pixel period, and the disagreement lasts until the next wrap of that axis. A counter that skips or repeats a value shows within one tick as a wrong count. A prescaler fault shows within a few clocks as a tick at the wrong spacing, or as counts that move between ticks. The bench also runs a copy with shifted sync starts, so that a pulse whose width depends on its start position is caught within one line for the horizontal pulse and within one frame for the vertical pulse.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

    // Raster segment of one axis, visited in this order.
    typedef enum logic [1:0] {
        SEG_ACTIVE = 2'd0,
        SEG_FRONT  = 2'd1,
        SEG_SYNC   = 2'd2,
        SEG_BACK   = 2'd3
    } seg_e;

endpackage

// File: rtl/vga_pixel_prescale.sv
module vga_pixel_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);

    logic tick_q;

    generate
        if (DIV < 2) begin : g_bypass
            // Every clock is a pixel clock once out of reset.
            always_ff @(posedge clk) begin
                if (rst) begin
                    tick_q <= 1'b0;
                end else begin
                    tick_q <= 1'b1;
                end
            end
        end else begin : g_divide
            localparam int            DW       = (DIV > 2) ? $clog2(DIV) : 1;
            localparam logic [DW-1:0] PH_WRAP  = DW'(DIV - 1);
            localparam logic [DW-1:0] PH_PRE   = DW'(DIV - 2);
            localparam logic [DW-1:0] PH_ONE   = DW'(1);

            logic [DW-1:0] phase_q;

            // tick_q is raised for the clock in which phase_q is at its wrap value.
            always_ff @(posedge clk) begin
                if (rst) begin
                    phase_q <= '0;
                    tick_q  <= 1'b0;
                end else begin
                    phase_q <= (phase_q == PH_WRAP) ? '0 : phase_q + PH_ONE;
                    tick_q  <= (phase_q == PH_PRE);
                end
            end
        end
    endgenerate

    assign tick_o = tick_q;

endmodule

// File: rtl/vga_axis_seq.sv
module vga_axis_seq
    import vga_timing_pkg::*;
#(
    parameter int ACTIVE      = 512,
    parameter int SYNC_START  = 592,
    parameter int SYNC_WIDTH  = 96,
    parameter int TOTAL       = 800,
    parameter int CW          = $clog2(TOTAL),
    parameter bit EDGE_AT_END = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] cnt_o,
    output logic          active_o,
    output logic          sync_o,
    output logic          edge_o
);

    // Last count of each segment; a state leaves its segment on a step from here.
    localparam logic [CW-1:0] ACT_LAST   = CW'(ACTIVE - 1);
    localparam logic [CW-1:0] FRONT_LAST = CW'(SYNC_START - 1);
    localparam logic [CW-1:0] SYNC_LAST  = CW'(SYNC_START + SYNC_WIDTH - 1);
    localparam logic [CW-1:0] AXIS_LAST  = CW'(TOTAL - 1);
    localparam logic [CW-1:0] CNT_ONE    = CW'(1);

    logic [CW-1:0] cnt_q;
    seg_e          seg_q;
    seg_e          seg_d;
    logic          at_last;

    assign at_last = (cnt_q == AXIS_LAST);

    // Next state: each transition is taken on a step from a segment's final count.
    always_comb begin
        seg_d = seg_q;
        unique case (seg_q)
            SEG_ACTIVE: if (cnt_q == ACT_LAST)   seg_d = SEG_FRONT;
            SEG_FRONT:  if (cnt_q == FRONT_LAST) seg_d = SEG_SYNC;
            SEG_SYNC:   if (cnt_q == SYNC_LAST)  seg_d = SEG_BACK;
            SEG_BACK:   if (at_last)             seg_d = SEG_ACTIVE;
        endcase
    end

    // State register together with its position counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            seg_q <= SEG_ACTIVE;
        end else if (step) begin
            cnt_q <= at_last ? '0 : cnt_q + CNT_ONE;
            seg_q <= seg_d;
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        cnt_o    = cnt_q;
        active_o = (seg_q == SEG_ACTIVE);
        sync_o   = (seg_q == SEG_SYNC);
    end

    generate
        if (EDGE_AT_END) begin : g_edge_last
            assign edge_o = at_last;
        end else begin : g_edge_first
            assign edge_o = (cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/vga_offset_timing.sv
module vga_offset_timing #(
    parameter  int CLK_DIV      = 4,
    parameter  int H_ACTIVE     = 512,
    parameter  int H_SYNC_START = 592,
    parameter  int H_SYNC_WIDTH = 96,
    parameter  int H_TOTAL      = 800,
    parameter  int V_ACTIVE     = 384,
    parameter  int V_SYNC_START = 443,
    parameter  int V_SYNC_WIDTH = 3,
    parameter  int V_TOTAL      = 525,
    localparam int XW           = $clog2(H_TOTAL),
    localparam int YW           = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          pix_tick,
    output logic [XW-1:0] pix_x,
    output logic [YW-1:0] line_y,
    output logic          hsync,
    output logic          vsync,
    output logic          h_active,
    output logic          v_active,
    output logic          line_end,
    output logic          frame_start
);

    logic tick;
    logic h_last;
    logic v_first;
    logic v_step;

    vga_pixel_prescale #(
        .DIV (CLK_DIV)
    ) u_prescale (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    vga_axis_seq #(
        .ACTIVE      (H_ACTIVE),
        .SYNC_START  (H_SYNC_START),
        .SYNC_WIDTH  (H_SYNC_WIDTH),
        .TOTAL       (H_TOTAL),
        .CW          (XW),
        .EDGE_AT_END (1'b1)
    ) u_h_axis (
        .clk      (clk),
        .rst      (rst),
        .step     (tick),
        .cnt_o    (pix_x),
        .active_o (h_active),
        .sync_o   (hsync),
        .edge_o   (h_last)
    );

    // A line advances on the tick that leaves the last pixel.
    assign v_step = tick & h_last;

    vga_axis_seq #(
        .ACTIVE      (V_ACTIVE),
        .SYNC_START  (V_SYNC_START),
        .SYNC_WIDTH  (V_SYNC_WIDTH),
        .TOTAL       (V_TOTAL),
        .CW          (YW),
        .EDGE_AT_END (1'b0)
    ) u_v_axis (
        .clk      (clk),
        .rst      (rst),
        .step     (v_step),
        .cnt_o    (line_y),
        .active_o (v_active),
        .sync_o   (vsync),
        .edge_o   (v_first)
    );

    assign pix_tick    = tick;
    assign line_end    = h_last;
    assign frame_start = v_first & (pix_x == '0);

endmodule

// File: rtl/vga_offset_timing_chk.sv
module vga_offset_timing_chk #(
    parameter int CLK_DIV      = 4,
    parameter int H_ACTIVE     = 512,
    parameter int H_SYNC_START = 592,
    parameter int H_SYNC_WIDTH = 96,
    parameter int H_TOTAL      = 800,
    parameter int V_ACTIVE     = 384,
    parameter int V_SYNC_START = 443,
    parameter int V_SYNC_WIDTH = 3,
    parameter int V_TOTAL      = 525
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       pix_tick,
    input logic [$clog2(H_TOTAL)-1:0] pix_x,
    input logic [$clog2(V_TOTAL)-1:0] line_y,
    input logic                       hsync,
    input logic                       vsync,
    input logic                       h_active,
    input logic                       v_active,
    input logic                       line_end,
    input logic                       frame_start
);

    localparam int            XW     = $clog2(H_TOTAL);
    localparam int            YW     = $clog2(V_TOTAL);
    localparam int            GW     = $clog2(CLK_DIV) + 2;
    localparam logic [XW-1:0] X_LAST = XW'(H_TOTAL - 1);
    localparam logic [XW-1:0] X_ONE  = XW'(1);
    localparam logic [XW-1:0] X_ACT  = XW'(H_ACTIVE);
    localparam logic [XW-1:0] X_SLO  = XW'(H_SYNC_START);
    localparam logic [XW-1:0] X_SHI  = XW'(H_SYNC_START + H_SYNC_WIDTH);
    localparam logic [YW-1:0] Y_LAST = YW'(V_TOTAL - 1);
    localparam logic [YW-1:0] Y_ONE  = YW'(1);
    localparam logic [YW-1:0] Y_ACT  = YW'(V_ACTIVE);
    localparam logic [YW-1:0] Y_SLO  = YW'(V_SYNC_START);
    localparam logic [YW-1:0] Y_SHI  = YW'(V_SYNC_START + V_SYNC_WIDTH);
    localparam logic [GW-1:0] G_GAP  = GW'(CLK_DIV - 1);
    localparam logic [GW-1:0] G_ONE  = GW'(1);

    // Clocks since the previous tick, so the spacing is checked without deep $past.
    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (pix_tick) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + G_ONE;
        end
    end

    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && seen_q) |-> (gap_q == G_GAP));

    a_r2_x_step: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && pix_x != X_LAST) |=> (pix_x == $past(pix_x) + X_ONE));

    a_r2_x_wrap: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && pix_x == X_LAST) |=> (pix_x == '0));

    a_r3_y_hold: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && pix_x != X_LAST) |=> $stable(line_y));

    a_r3_y_step: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && line_end && line_y != Y_LAST) |=> (line_y == $past(line_y) + Y_ONE));

    a_r3_y_wrap: assert property (@(posedge clk) disable iff (rst)
        (pix_tick && line_end && line_y == Y_LAST) |=> (line_y == '0));

    a_r4_h_window: assert property (@(posedge clk) disable iff (rst)
        h_active == (pix_x < X_ACT));

    a_r4_v_window: assert property (@(posedge clk) disable iff (rst)
        v_active == (line_y < Y_ACT));

    a_r5_hsync_window: assert property (@(posedge clk) disable iff (rst)
        hsync == ((pix_x >= X_SLO) && (pix_x < X_SHI)));

    a_r6_vsync_window: assert property (@(posedge clk) disable iff (rst)
        vsync == ((line_y >= Y_SLO) && (line_y < Y_SHI)));

    a_r7_line_end: assert property (@(posedge clk) disable iff (rst)
        line_end == (pix_x == X_LAST));

    a_r7_frame_start: assert property (@(posedge clk) disable iff (rst)
        frame_start == (pix_x == '0 && line_y == '0));

    a_r8_reset_values: assert property (@(posedge clk)
        $past(rst) |-> (pix_x == '0 && line_y == '0 && !hsync && !vsync &&
                        h_active && v_active && !line_end && frame_start && !pix_tick));

    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !pix_tick |=> ($stable(pix_x) && $stable(line_y) && $stable(hsync) && $stable(vsync)));

endmodule

bind vga_offset_timing vga_offset_timing_chk #(
    .CLK_DIV      (CLK_DIV),
    .H_ACTIVE     (H_ACTIVE),
    .H_SYNC_START (H_SYNC_START),
    .H_SYNC_WIDTH (H_SYNC_WIDTH),
    .H_TOTAL      (H_TOTAL),
    .V_ACTIVE     (V_ACTIVE),
    .V_SYNC_START (V_SYNC_START),
    .V_SYNC_WIDTH (V_SYNC_WIDTH),
    .V_TOTAL      (V_TOTAL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pix_tick    (pix_tick),
    .pix_x       (pix_x),
    .line_y      (line_y),
    .hsync       (hsync),
    .vsync       (vsync),
    .h_active    (h_active),
    .v_active    (v_active),
    .line_end    (line_end),
    .frame_start (frame_start)
);

// File: tb/vga_offset_timing_tb.sv
module vga_offset_timing_tb;

    localparam int DIV     = 4;
    localparam int HT      = 800;
    localparam int HA      = 512;
    localparam int HSS     = 592;
    localparam int HSW     = 96;
    localparam int VT      = 20;
    localparam int VA      = 12;
    localparam int VSS     = 15;
    localparam int VSW     = 3;
    localparam int ALT_HSS = 600;
    localparam int ALT_VSS = 16;
    localparam int XW      = $clog2(HT);
    localparam int YW      = $clog2(VT);

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic          pix_tick, hsync, vsync, h_active, v_active, line_end, frame_start;
    logic [XW-1:0] pix_x;
    logic [YW-1:0] line_y;

    logic          a_tick, a_hs, a_vs, a_ha, a_va, a_le, a_fs;
    logic [XW-1:0] a_x;
    logic [YW-1:0] a_y;

    always #10 clk = ~clk;

    vga_offset_timing #(
        .CLK_DIV (DIV), .H_ACTIVE (HA), .H_SYNC_START (HSS), .H_SYNC_WIDTH (HSW), .H_TOTAL (HT),
        .V_ACTIVE (VA), .V_SYNC_START (VSS), .V_SYNC_WIDTH (VSW), .V_TOTAL (VT)
    ) u_dut (
        .clk (clk), .rst (rst), .pix_tick (pix_tick), .pix_x (pix_x), .line_y (line_y),
        .hsync (hsync), .vsync (vsync), .h_active (h_active), .v_active (v_active),
        .line_end (line_end), .frame_start (frame_start)
    );

    // Copy with both sync pulses moved, same widths.
    vga_offset_timing #(
        .CLK_DIV (DIV), .H_ACTIVE (HA), .H_SYNC_START (ALT_HSS), .H_SYNC_WIDTH (HSW), .H_TOTAL (HT),
        .V_ACTIVE (VA), .V_SYNC_START (ALT_VSS), .V_SYNC_WIDTH (VSW), .V_TOTAL (VT)
    ) u_alt (
        .clk (clk), .rst (rst), .pix_tick (a_tick), .pix_x (a_x), .line_y (a_y),
        .hsync (a_hs), .vsync (a_vs), .h_active (a_ha), .v_active (a_va),
        .line_end (a_le), .frame_start (a_fs)
    );

    typedef struct {
        bit is_rst;
        bit tick;
        int x;
        int y;
        bit ha, va, hs, vs, le, fs, ahs, avs;
    } exp_t;

    exp_t sb_q[$];
    exp_t e;
    int   n_edges  = 0;
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    bit   have_prev = 1'b0;
    bit   prev_tick, prev_rst, prev_hs, prev_vs;
    int   prev_x, prev_y;

    // Driver: expected outputs after the n-th edge since reset release.
    task automatic push_expected(input int n, input bit in_rst);
        exp_t it;
        int   p;
        p         = n / DIV;
        it.is_rst = in_rst;
        it.tick   = (n % DIV) == DIV - 1;
        it.x      = p % HT;
        it.y      = (p / HT) % VT;
        it.ha     = it.x < HA;
        it.va     = it.y < VA;
        it.hs     = it.x >= HSS && it.x < HSS + HSW;
        it.vs     = it.y >= VSS && it.y < VSS + VSW;
        it.le     = it.x == HT - 1;
        it.fs     = it.x == 0 && it.y == 0;
        it.ahs    = it.x >= ALT_HSS && it.x < ALT_HSS + HSW;
        it.avs    = it.y >= ALT_VSS && it.y < ALT_VSS + VSW;
        sb_q.push_back(it);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    always @(posedge clk) begin
        if (rst) n_edges = 0;
        else     n_edges = n_edges + 1;
        push_expected(n_edges, rst);
    end

    // Monitor: pop one expected item per clock and compare away from the edge.
    always @(negedge clk) begin
        if (!done && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            if (e.is_rst) begin
                // R8: values left by a clock edge taken while reset is held
                check("R8", "pix_tick", int'(pix_tick), int'(e.tick));
                check("R8", "pix_x", int'(pix_x), e.x);
                check("R8", "line_y", int'(line_y), e.y);
                check("R8", "h_active", int'(h_active), int'(e.ha));
                check("R8", "v_active", int'(v_active), int'(e.va));
                check("R8", "hsync", int'(hsync), int'(e.hs));
                check("R8", "vsync", int'(vsync), int'(e.vs));
                check("R8", "line_end", int'(line_end), int'(e.le));
                check("R8", "frame_start", int'(frame_start), int'(e.fs));
            end else begin
                check("R1", "pix_tick", int'(pix_tick), int'(e.tick));
                check("R2", "pix_x", int'(pix_x), e.x);
                check("R3", "line_y", int'(line_y), e.y);
                check("R4", "h_active", int'(h_active), int'(e.ha));
                check("R4", "v_active", int'(v_active), int'(e.va));
                check("R5", "hsync", int'(hsync), int'(e.hs));
                check("R6", "vsync", int'(vsync), int'(e.vs));
                check("R7", "line_end", int'(line_end), int'(e.le));
                check("R7", "frame_start", int'(frame_start), int'(e.fs));
                check("R10", "shifted hsync", int'(a_hs), int'(e.ahs));
                check("R10", "shifted vsync", int'(a_vs), int'(e.avs));
                // R9: nothing moves after an edge without a tick
                if (have_prev && !prev_rst && !prev_tick) begin
                    check("R9", "pix_x held", int'(pix_x), prev_x);
                    check("R9", "line_y held", int'(line_y), prev_y);
                    check("R9", "hsync held", int'(hsync), int'(prev_hs));
                    check("R9", "vsync held", int'(vsync), int'(prev_vs));
                end
            end
            have_prev = 1'b1;
            prev_rst  = e.is_rst;
            prev_tick = pix_tick;
            prev_x    = int'(pix_x);
            prev_y    = int'(line_y);
            prev_hs   = hsync;
            prev_vs   = vsync;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // Two full frames, then part way into a third before a second reset.
        repeat (2 * HT * VT * DIV + 5000) @(posedge clk);
        @(negedge clk) rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (3000) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fails++;
            $display("FAIL R2 watchdog: actual %0d cycles expected completion", 190000);
            summary();
            $finish;
        end
    end

endmodule